// File: doc/BRIEF.md
# Dual-Width Receive Frame CRC Checker

This block checks the integrity of each received frame as its bytes arrive after the delimiter. It runs every byte through a CRC register, including the CRC field that the sender appended. When the frame ends, it compares the final register value with the fixed residue that every error-free frame leaves behind. It does not need to know where the CRC field sits. It only needs to know where the frame starts and ends.

A width select chooses between an 8-bit check and a 32-bit check for each frame, and the block samples it when the frame starts. Both engines shift bits in least-significant-bit first, with the register reflected. A sender therefore appends the complement of its register, low byte first. One cycle after the frame-end pulse, the block raises either a pass flag or a fail flag for a single cycle.

Top module: `rxcrc_dual_check`

## Requirements
- R1: While reset is asserted, and after it is released, both result flags are low and no frame is open. A frame-end pulse in a frame that was cut short by reset raises no flag.
- R2: With the 32-bit width selected (select = 1), the check uses the polynomial x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. The register is reflected, bits enter least-significant first, and the start value is FFFFFFFFh. The frame passes exactly when the final value equals DEBB20E3h.
- R3: With the 8-bit width selected (select = 0), the check uses the polynomial x^8+x^5+x+1. The register is reflected, bits enter least-significant first, and the start value is FFh. The frame passes exactly when the final value equals 66h.
- R4: A frame-start pulse reloads the start value. A byte marked valid in the same cycle is folded in on top of that start value.
- R5: The register advances only on a valid byte inside an open frame. Idle cycles between bytes leave the result unchanged.
- R6: A frame-end pulse closes the frame and includes any valid byte in the same cycle. In the next cycle exactly one of pass and fail is high, and it stays high for that one cycle only.
- R7: The width is sampled at frame start. Changing the select while a frame is open has no effect on that frame's result.
- R8: A frame-end pulse while no frame is open raises no flag. Valid bytes outside a frame do not affect the next frame.
- R9: A frame-start pulse inside an open frame discards the bytes seen so far and starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle pulse on the first byte cycle of a frame |
| frame_end_i | input | 1 | One-cycle pulse on the last byte cycle of a frame |
| byte_valid_i | input | 1 | Qualifies byte_i |
| byte_i | input | 8 | Received byte after the delimiter |
| wide_sel_i | input | 1 | 1 selects the 32-bit check, 0 the 8-bit check; sampled at frame start |
| crc_pass_o | output | 1 | One-cycle pulse: the frame matched its residue |
| crc_fail_o | output | 1 | One-cycle pulse: the frame did not match |

## Verification
The bench covers three corner cases that each catch a specific defect.

- **Empty payloads.** A frame made only of its CRC field starts from the bare start value. A wrong start value or a wrong residue constant turns these passes into fails.
- **Single-cycle frames.** Start and end are pulsed in one cycle. A design that drops the byte in the start cycle, or evaluates before folding in the last byte, flags the wrong outcome.
- **Idle gaps.** Gaps are filled with a junk byte and a flipped width select. A design that clocks bytes while valid is low, or that follows the select mid-frame, fails frames that are actually good.

Two more cases target state handling. Stray frame-end pulses, bytes sent outside any frame, restarts in the middle of a frame and a reset during a frame all check that nothing carries over. Corrupted frames, with the flipped bit placed in the payload or in the last CRC byte, check that a bad frame is never reported as a pass.

// File: rtl/rxcrc_pkg.sv
package rxcrc_pkg;

  typedef enum logic {
    CRCW_NARROW = 1'b0,
    CRCW_WIDE   = 1'b1
  } crc_width_e;

  localparam int unsigned BYTE_W = 8;

  localparam int unsigned NARROW_W = 8;
  localparam logic [NARROW_W-1:0] NARROW_POLY_REFL = 8'hC4;
  localparam logic [NARROW_W-1:0] NARROW_INIT      = 8'hFF;
  localparam logic [NARROW_W-1:0] NARROW_RESIDUE   = 8'h66;

  localparam int unsigned WIDE_W = 32;
  localparam logic [WIDE_W-1:0] WIDE_POLY_REFL = 32'hEDB8_8320;
  localparam logic [WIDE_W-1:0] WIDE_INIT      = 32'hFFFF_FFFF;
  localparam logic [WIDE_W-1:0] WIDE_RESIDUE   = 32'hDEBB_20E3;

endpackage

// File: rtl/rxcrc_lane.sv
module rxcrc_lane
  import rxcrc_pkg::*;
#(
  parameter int unsigned          CRC_W   = 32,
  parameter int unsigned          DATA_W  = BYTE_W,
  parameter logic [CRC_W-1:0]     POLY    = '1,
  parameter logic [CRC_W-1:0]     INIT    = '1,
  parameter logic [CRC_W-1:0]     RESIDUE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              advance_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              match_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] folded;

  // fold one byte, least-significant bit first, into the reflected register
  always_comb begin
    base   = restart_i ? INIT : crc_q;
    folded = base;
    for (int b = 0; b < int'(DATA_W); b++) begin
      if (folded[0] ^ data_i[b]) begin
        folded = (folded >> 1) ^ POLY;
      end else begin
        folded = folded >> 1;
      end
    end
  end

  always_comb begin
    if (advance_i) begin
      crc_d = folded;
    end else begin
      crc_d = base;
    end
  end

  assign match_o = (crc_d == RESIDUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= INIT;
    end else if (advance_i || restart_i) begin
      crc_q <= crc_d;
    end
  end

  // R5
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i && !restart_i) |=> $stable(crc_q));

  // R4
  crc_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !advance_i) |=> (crc_q == INIT));

endmodule

// File: rtl/rxcrc_frame_seq.sv
module rxcrc_frame_seq
  import rxcrc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  input  logic valid_i,
  input  logic wide_sel_i,
  input  logic narrow_match_i,
  input  logic wide_match_i,
  output logic restart_o,
  output logic advance_o,
  output logic pass_o,
  output logic fail_o
);

  crc_width_e width_q, width_d, width_eff;
  logic       open_q, open_d;
  logic       pass_q, pass_d;
  logic       fail_q, fail_d;
  logic       in_frame;
  logic       evaluate;
  logic       sel_match;

  assign in_frame  = open_q || start_i;
  assign restart_o = start_i;
  assign advance_o = valid_i && in_frame;
  assign evaluate  = end_i && in_frame;
  assign width_eff = start_i ? crc_width_e'(wide_sel_i) : width_q;

  always_comb begin
    sel_match = (width_eff == CRCW_WIDE) ? wide_match_i : narrow_match_i;
    pass_d    = evaluate && sel_match;
    fail_d    = evaluate && !sel_match;
    width_d   = width_eff;
    if (end_i) begin
      open_d = 1'b0;
    end else if (start_i) begin
      open_d = 1'b1;
    end else begin
      open_d = open_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      width_q <= CRCW_NARROW;
    end else begin
      open_q <= open_d;
      pass_q <= pass_d;
      fail_q <= fail_d;
      if (start_i) begin
        width_q <= width_d;
      end
    end
  end

  assign pass_o = pass_q;
  assign fail_o = fail_q;

  // R6
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_q && fail_q));

  // R6
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_q || fail_q) |-> $past(end_i));

  // R7
  width_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && !start_i) |=> $stable(width_q));

  // R8
  stray_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && !start_i && end_i) |=> !(pass_q || fail_q));

endmodule

// File: rtl/rxcrc_dual_check.sv
module rxcrc_dual_check
  import rxcrc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_start_i,
  input  logic        frame_end_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  input  logic        wide_sel_i,
  output logic        crc_pass_o,
  output logic        crc_fail_o
);

  logic restart;
  logic advance;
  logic narrow_match;
  logic wide_match;

  rxcrc_frame_seq seq_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (frame_start_i),
    .end_i          (frame_end_i),
    .valid_i        (byte_valid_i),
    .wide_sel_i     (wide_sel_i),
    .narrow_match_i (narrow_match),
    .wide_match_i   (wide_match),
    .restart_o      (restart),
    .advance_o      (advance),
    .pass_o         (crc_pass_o),
    .fail_o         (crc_fail_o)
  );

  // R3
  rxcrc_lane #(
    .CRC_W   (NARROW_W),
    .DATA_W  (BYTE_W),
    .POLY    (NARROW_POLY_REFL),
    .INIT    (NARROW_INIT),
    .RESIDUE (NARROW_RESIDUE)
  ) narrow_lane_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .advance_i (advance),
    .data_i    (byte_i),
    .match_o   (narrow_match)
  );

  // R2
  rxcrc_lane #(
    .CRC_W   (WIDE_W),
    .DATA_W  (BYTE_W),
    .POLY    (WIDE_POLY_REFL),
    .INIT    (WIDE_INIT),
    .RESIDUE (WIDE_RESIDUE)
  ) wide_lane_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .advance_i (advance),
    .data_i    (byte_i),
    .match_o   (wide_match)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !(crc_pass_o || crc_fail_o));

endmodule

// File: tb/rxcrc_dual_check_tb.sv
module rxcrc_dual_check_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0;
  logic       eof = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] dat = 8'h00;
  logic       wsel = 1'b0;
  logic       pass_w;
  logic       fail_w;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] fbuf [0:63];
  int         flen;

  always #5 clk = ~clk;

  rxcrc_dual_check dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .frame_start_i (sof),
    .frame_end_i   (eof),
    .byte_valid_i  (vld),
    .byte_i        (dat),
    .wide_sel_i    (wsel),
    .crc_pass_o    (pass_w),
    .crc_fail_o    (fail_w)
  );

  // fields: [31] wide, [30] gaps, [29:24] payload len, [23:16] seed,
  //         [15:8] corrupt position (1-based, 0 none), [0] expect pass
  localparam int NVEC = 10;
  localparam logic [31:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 6'd5,  8'h11, 8'd0,  7'd0, 1'b1},
    {1'b1, 1'b1, 6'd12, 8'h3A, 8'd0,  7'd0, 1'b1},
    {1'b1, 1'b0, 6'd6,  8'h05, 8'd3,  7'd0, 1'b0},
    {1'b0, 1'b0, 6'd4,  8'h77, 8'd0,  7'd0, 1'b1},
    {1'b0, 1'b1, 6'd9,  8'hC1, 8'd0,  7'd0, 1'b1},
    {1'b0, 1'b0, 6'd7,  8'h22, 8'd8,  7'd0, 1'b0},
    {1'b1, 1'b0, 6'd0,  8'h00, 8'd0,  7'd0, 1'b1},
    {1'b0, 1'b0, 6'd0,  8'h00, 8'd0,  7'd0, 1'b1},
    {1'b1, 1'b1, 6'd20, 8'h9E, 8'd24, 7'd0, 1'b0},
    {1'b0, 1'b1, 6'd3,  8'h4D, 8'd1,  7'd0, 1'b0}
  };

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_fold(input logic wide, input logic [31:0] c,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ (wide ? 32'hEDB8_8320 : 32'h0000_00C4);
      else             r = r >> 1;
    end
    return r;
  endfunction

  // fill fbuf with payload then the complemented CRC, low byte first
  task automatic build_frame(input logic wide, input int len, input logic [7:0] seed);
    logic [31:0] c;
    int nb;
    c = wide ? 32'hFFFF_FFFF : 32'h0000_00FF;
    for (int i = 0; i < len; i++) begin
      fbuf[i] = 8'((int'(seed) * 7 + i * 13) ^ (i << 3));
      c = crc_fold(wide, c, fbuf[i]);
    end
    c  = ~c;
    nb = wide ? 4 : 1;
    for (int i = 0; i < nb; i++) fbuf[len + i] = c[8*i +: 8];
    flen = len + nb;
  endtask

  task automatic idle();
    @(negedge clk);
    sof = 1'b0; eof = 1'b0; vld = 1'b0; dat = 8'h00;
  endtask

  task automatic send(input logic wide, input logic gaps);
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      sof = (i == 0); eof = (i == flen - 1); vld = 1'b1; dat = fbuf[i];
      wsel = wide;
      if (gaps && i != flen - 1) begin
        @(negedge clk);
        sof = 1'b0; eof = 1'b0; vld = 1'b0; dat = 8'hA5; wsel = ~wide;
      end
    end
    idle();
  endtask

  task automatic expect_result(input bit exp_pass, input string req);
    chk(pass_w == exp_pass && fail_w == !exp_pass, req, {pass_w, fail_w},
        {exp_pass, !exp_pass});
    @(negedge clk);
    chk(!pass_w && !fail_w, "R6 one-cycle", {pass_w, fail_w}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pass_w && !fail_w, "R1 in reset", {pass_w, fail_w}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pass_w && !fail_w, "R1 after release", {pass_w, fail_w}, 0);

    // R8: stray end pulse with no open frame
    @(negedge clk); eof = 1'b1;
    idle();
    chk(!pass_w && !fail_w, "R8 stray end", {pass_w, fail_w}, 0);

    // R8: bytes outside a frame, then a good frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); vld = 1'b1; dat = 8'(i * 37 + 5);
    end
    idle();
    chk(!pass_w && !fail_w, "R8 loose bytes", {pass_w, fail_w}, 0);
    build_frame(1'b1, 6, 8'h52);
    send(1'b1, 1'b0);
    expect_result(1'b1, "R8 frame after loose bytes");

    // table walk: R2 R3 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] e;
      int cp;
      e = VECS[v];
      build_frame(e[31], int'(e[29:24]), e[23:16]);
      cp = int'(e[15:8]);
      if (cp != 0) fbuf[cp - 1] = fbuf[cp - 1] ^ 8'h01;
      send(e[31], e[30]);
      expect_result(e[0], e[31] ? "R2 vector" : "R3 vector");
    end

    // R9: restart inside an open frame
    @(negedge clk); sof = 1'b1; vld = 1'b1; dat = 8'h3C; wsel = 1'b0;
    @(negedge clk); sof = 1'b0; dat = 8'h99;
    build_frame(1'b0, 5, 8'h61);
    send(1'b0, 1'b0);
    expect_result(1'b1, "R9 restart");

    // R4 + R6: start and end in the same cycle, 8-bit empty frame (byte 00h passes)
    @(negedge clk); sof = 1'b1; eof = 1'b1; vld = 1'b1; dat = 8'h00; wsel = 1'b0;
    idle();
    expect_result(1'b1, "R4 single-cycle good");
    @(negedge clk); sof = 1'b1; eof = 1'b1; vld = 1'b1; dat = 8'h01; wsel = 1'b0;
    idle();
    expect_result(1'b0, "R4 single-cycle bad");

    // R1: reset cuts a frame; later end pulse raises nothing
    @(negedge clk); sof = 1'b1; vld = 1'b1; dat = 8'h12; wsel = 1'b1;
    @(negedge clk); sof = 1'b0; dat = 8'h34;
    rst_n = 1'b0;
    @(negedge clk); vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk); eof = 1'b1;
    idle();
    chk(!pass_w && !fail_w, "R1 end after reset", {pass_w, fail_w}, 0);

    idle();
    summary();
  end

endmodule